// File: doc/BRIEF.md
# Fixed-Length Link Cell Framer

This block builds the outgoing byte stream of a full-duplex point-to-point fiber link. The line never goes idle: it carries back-to-back cells of identical length, and no start-of-message marker is sent. Each cell has three parts in a fixed order: a 32-byte header of sixteen 16-bit words, a 320-byte payload slot, and a 256-byte slot set aside for an error-correction encoder. That encoder is outside the block, so the slot is filled with zeros here.

At the first byte of every cell the framer picks one payload source. A pattern source comes first, then a real-time buffer source, then a non-real-time buffer source. A buffer source is eligible only when the peer has advertised its destination receive buffer as free. When no source is eligible, a no-op cell with a zero payload goes out. In the same cycle the framer takes a snapshot of the local flow-control bitmaps, the sequence numbers, the error counters and any pending remote init-register write, and places them in the header. For each destination and each traffic class it keeps a running count of 64-byte chunks. This count goes into the header as the cumulative buffer offset.

Payload sources see a one-cycle grant at cell start. After that they see a read strobe for each payload byte they must supply. The byte they present in a strobe cycle appears on the line one cycle later.

Top module: `link_cell_framer`

## Requirements
- R1: A cell is 608 bytes long. `out_sof` is high for exactly the first byte of every cell, so it is high once every 608 cycles. The first cell begins one cycle after reset is released.
- R2: Header word 0 is the command word. Bits 15:12 hold the destination, bit 11 the first-cell flag, bit 10 the last-cell flag, bits 9:8 the type (0 pattern, 1 real-time, 2 non-real-time, 3 no-op), bit 7 the init write-enable, and bits 6:0 are zero. Every header word goes out high byte first.
- R3: Header word 1 is the cumulative buffer length in 64-byte chunks, including the current cell. For a buffer cell flagged first it equals the chunk count of that cell. Otherwise it equals the last offset sent for the same class and destination plus the chunk count. A pattern cell carries 5 and a no-op cell carries 0.
- R4: When `init_req` is high at cell start, command bit 7 is set and words 2 and 3 carry `init_data` (upper half first). `init_ack` pulses once in that cycle. Otherwise bit 7 and words 2 and 3 are zero.
- R5: Words 4 to 7 carry the local non-real-time free, real-time free, non-real-time full and real-time full bitmaps, in that order. Word 9 carries the next expected incoming sequence number. Words 10 to 15 carry the six error counters, with counter k taken from `err_cnts[16k+15:16k]`. All of these are sampled at cell start.
- R6: Word 8 carries the outgoing sequence number. It is 0 in the first cell after reset and rises by one in each following cell, no-op cells included, wrapping modulo 2^16.
- R7: The source is chosen with fixed priority: pattern first, then real-time, then non-real-time, then no-op. Exactly the chosen source gets a one-cycle grant at cell start.
- R8: A real-time or non-real-time request is eligible only if the peer's free bit for its destination is set. A blocked request gets no grant and leaves the line unchanged.
- R9: A no-op cell has destination 0, both flags clear and an all-zero payload, and no source sees a read strobe.
- R10: A pattern cell uses all 5 chunks, with destination 0 and both flags set. A buffer cell uses its requested chunk count, and counts above 5 are taken as 5. The chosen source gets exactly 64 times the used chunk count of read strobes. Its bytes fill the front of the payload slot in order, and the rest of the slot is zero.
- R11: All 256 bytes of the error-correction slot are zero.
- R12: During reset `out_byte` and `out_sof` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_req | input | 1 | Pattern source has a cell ready |
| pat_gnt | output | 1 | Pattern source chosen (cell-start pulse) |
| pat_rd | output | 1 | Pattern byte taken this cycle |
| pat_data | input | 8 | Pattern payload byte |
| rt_req | input | 1 | Real-time source has a cell ready |
| rt_dest | input | 4 | Real-time destination buffer |
| rt_first | input | 1 | Real-time cell opens its buffer |
| rt_last | input | 1 | Real-time cell closes its buffer |
| rt_chunks | input | 3 | Real-time 64-byte chunks in this cell |
| rt_gnt | output | 1 | Real-time source chosen |
| rt_rd | output | 1 | Real-time byte taken this cycle |
| rt_data | input | 8 | Real-time payload byte |
| nrt_req | input | 1 | Non-real-time source has a cell ready |
| nrt_dest | input | 4 | Non-real-time destination buffer |
| nrt_first | input | 1 | Non-real-time cell opens its buffer |
| nrt_last | input | 1 | Non-real-time cell closes its buffer |
| nrt_chunks | input | 3 | Non-real-time chunks in this cell |
| nrt_gnt | output | 1 | Non-real-time source chosen |
| nrt_rd | output | 1 | Non-real-time byte taken this cycle |
| nrt_data | input | 8 | Non-real-time payload byte |
| peer_rt_avail | input | 16 | Peer real-time receive buffers free |
| peer_nrt_avail | input | 16 | Peer non-real-time receive buffers free |
| init_req | input | 1 | Remote init-register write pending |
| init_data | input | 32 | Remote init-register write value |
| init_ack | output | 1 | Init write placed in this cell |
| loc_nrt_free | input | 16 | Local non-real-time buffers free |
| loc_rt_free | input | 16 | Local real-time buffers free |
| loc_nrt_full | input | 16 | Local non-real-time buffers filled |
| loc_rt_full | input | 16 | Local real-time buffers filled |
| rx_next_seq | input | 16 | Next expected incoming sequence number |
| err_cnts | input | 96 | Six 16-bit error/event counters |
| out_byte | output | 8 | Line byte |
| out_sof | output | 1 | First byte of a cell |

## Verification
The assertions assume that request, destination and availability inputs are steady around the cell-start edge. They also assume that `init_req` is dropped once `init_ack` has been seen, so that one write is never reported in two back-to-back cells. The bench meets both conditions because it changes every input only on a falling edge, in the same cycle in which the last byte of the previous cell is seen. It programs each cell's inputs once and clears `init_req` in the cell that follows the acknowledged one. Chunk counts in the stimulus stay within 1 to 7, so the clamp is exercised without depending on values that are never meant to appear.

// File: rtl/lcf_pkg.sv
package lcf_pkg;
  localparam int WORD_W = 16;
  localparam int DEST_W = 4;
  localparam int NDEST  = 1 << DEST_W;

  typedef enum logic [1:0] {
    CT_PAT = 2'd0,
    CT_RT  = 2'd1,
    CT_NRT = 2'd2,
    CT_NOP = 2'd3
  } cell_type_e;

  // command word: dest | first | last | type | init write enable | zeros
  function automatic logic [WORD_W-1:0] pack_cmd(
    input logic [DEST_W-1:0] dest,
    input logic              first,
    input logic              last,
    input cell_type_e        ct,
    input logic              init_we
  );
    return {dest, first, last, ct, init_we, 7'd0};
  endfunction

  // cumulative chunk count: restarts on a first cell
  function automatic logic [WORD_W-1:0] next_offset(
    input logic              first,
    input logic [WORD_W-1:0] prev,
    input logic [WORD_W-1:0] chunks
  );
    return first ? chunks : prev + chunks;
  endfunction
endpackage

// File: rtl/lcf_arbiter.sv
module lcf_arbiter
  import lcf_pkg::*;
(
  input  logic              pat_req,
  input  logic              rt_req,
  input  logic [DEST_W-1:0] rt_dest,
  input  logic              nrt_req,
  input  logic [DEST_W-1:0] nrt_dest,
  input  logic [NDEST-1:0]  peer_rt_avail,
  input  logic [NDEST-1:0]  peer_nrt_avail,
  output logic              rt_ok,
  output logic              nrt_ok,
  output cell_type_e        pick
);
  assign rt_ok  = rt_req  && peer_rt_avail[rt_dest];
  assign nrt_ok = nrt_req && peer_nrt_avail[nrt_dest];

  always_comb begin
    if (pat_req)     pick = CT_PAT;
    else if (rt_ok)  pick = CT_RT;
    else if (nrt_ok) pick = CT_NRT;
    else             pick = CT_NOP;
  end
endmodule

// File: rtl/lcf_offset_table.sv
module lcf_offset_table
  import lcf_pkg::*;
#(
  parameter int CHK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [DEST_W-1:0] dest,
  input  logic              first,
  input  logic [CHK_W-1:0]  chunks,
  output logic [WORD_W-1:0] off_next
);
  logic [WORD_W-1:0] tab_q [NDEST];

  assign off_next = next_offset(first, tab_q[dest], WORD_W'(chunks));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDEST; i++) tab_q[i] <= '0;
    end else if (upd) begin
      tab_q[dest] <= off_next;
    end
  end
endmodule

// File: rtl/lcf_hdr_sel.sv
module lcf_hdr_sel
  import lcf_pkg::*;
#(
  parameter int NWORDS = 16,
  localparam int HB_W  = $clog2(NWORDS * 2)
) (
  input  logic [NWORDS*WORD_W-1:0] words,
  input  logic [HB_W-1:0]          bsel,
  output logic [7:0]               hbyte
);
  logic [HB_W-2:0]   wsel;
  logic [WORD_W-1:0] word;

  assign wsel  = bsel[HB_W-1:1];
  assign word  = words[wsel*WORD_W +: WORD_W];
  assign hbyte = bsel[0] ? word[7:0] : word[15:8];
endmodule

// File: rtl/link_cell_framer.sv
module link_cell_framer
  import lcf_pkg::*;
#(
  parameter int NCNT        = 6,
  parameter int PAY_BYTES   = 320,
  parameter int ECC_BYTES   = 256,
  parameter int CHUNK_BYTES = 64,
  localparam int PAY_CHUNKS = PAY_BYTES / CHUNK_BYTES,
  localparam int CHK_W      = $clog2(PAY_CHUNKS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pat_req,
  output logic                   pat_gnt,
  output logic                   pat_rd,
  input  logic [7:0]             pat_data,
  input  logic                   rt_req,
  input  logic [DEST_W-1:0]      rt_dest,
  input  logic                   rt_first,
  input  logic                   rt_last,
  input  logic [CHK_W-1:0]       rt_chunks,
  output logic                   rt_gnt,
  output logic                   rt_rd,
  input  logic [7:0]             rt_data,
  input  logic                   nrt_req,
  input  logic [DEST_W-1:0]      nrt_dest,
  input  logic                   nrt_first,
  input  logic                   nrt_last,
  input  logic [CHK_W-1:0]       nrt_chunks,
  output logic                   nrt_gnt,
  output logic                   nrt_rd,
  input  logic [7:0]             nrt_data,
  input  logic [NDEST-1:0]       peer_rt_avail,
  input  logic [NDEST-1:0]       peer_nrt_avail,
  input  logic                   init_req,
  input  logic [2*WORD_W-1:0]    init_data,
  output logic                   init_ack,
  input  logic [WORD_W-1:0]      loc_nrt_free,
  input  logic [WORD_W-1:0]      loc_rt_free,
  input  logic [WORD_W-1:0]      loc_nrt_full,
  input  logic [WORD_W-1:0]      loc_rt_full,
  input  logic [WORD_W-1:0]      rx_next_seq,
  input  logic [NCNT*WORD_W-1:0] err_cnts,
  output logic [7:0]             out_byte,
  output logic                   out_sof
);
  localparam int HDR_WORDS  = 10 + NCNT;
  localparam int HDR_BYTES  = 2 * HDR_WORDS;
  localparam int CELL_BYTES = HDR_BYTES + PAY_BYTES + ECC_BYTES;
  localparam int IDX_W      = $clog2(CELL_BYTES);
  localparam int HB_W       = $clog2(HDR_BYTES);

  // ---------------- position within the cell ----------------
  logic [IDX_W-1:0] idx_q;
  logic             cell_start;
  logic             in_hdr;
  logic             in_pay;
  logic [IDX_W-1:0] pay_pos;

  assign cell_start = (idx_q == '0);
  assign in_hdr     = idx_q < IDX_W'(HDR_BYTES);
  assign in_pay     = !in_hdr && (idx_q < IDX_W'(HDR_BYTES + PAY_BYTES));
  assign pay_pos    = idx_q - IDX_W'(HDR_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n)                                idx_q <= '0;
    else if (idx_q == IDX_W'(CELL_BYTES - 1)) idx_q <= '0;
    else                                       idx_q <= idx_q + 1'b1;
  end

  // ---------------- source selection ----------------
  cell_type_e pick;
  logic       rt_ok;
  logic       nrt_ok;

  lcf_arbiter u_arb (
    .pat_req        (pat_req),
    .rt_req         (rt_req),
    .rt_dest        (rt_dest),
    .nrt_req        (nrt_req),
    .nrt_dest       (nrt_dest),
    .peer_rt_avail  (peer_rt_avail),
    .peer_nrt_avail (peer_nrt_avail),
    .rt_ok          (rt_ok),
    .nrt_ok         (nrt_ok),
    .pick           (pick)
  );

  assign pat_gnt  = cell_start && (pick == CT_PAT);
  assign rt_gnt   = cell_start && (pick == CT_RT);
  assign nrt_gnt  = cell_start && (pick == CT_NRT);
  assign init_ack = cell_start && init_req;

  function automatic logic [CHK_W-1:0] clamp_chunks(input logic [CHK_W-1:0] c);
    return (c > CHK_W'(PAY_CHUNKS)) ? CHK_W'(PAY_CHUNKS) : c;
  endfunction

  // ---------------- per-class offset tables ----------------
  logic              tab_upd    [2];
  logic [DEST_W-1:0] tab_dest   [2];
  logic              tab_first  [2];
  logic [CHK_W-1:0]  tab_chunks [2];
  logic [WORD_W-1:0] tab_off    [2];

  assign tab_upd[0]    = rt_gnt;
  assign tab_dest[0]   = rt_dest;
  assign tab_first[0]  = rt_first;
  assign tab_chunks[0] = clamp_chunks(rt_chunks);
  assign tab_upd[1]    = nrt_gnt;
  assign tab_dest[1]   = nrt_dest;
  assign tab_first[1]  = nrt_first;
  assign tab_chunks[1] = clamp_chunks(nrt_chunks);

  generate
    for (genvar g = 0; g < 2; g++) begin : g_class
      lcf_offset_table #(.CHK_W(CHK_W)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (tab_upd[g]),
        .dest     (tab_dest[g]),
        .first    (tab_first[g]),
        .chunks   (tab_chunks[g]),
        .off_next (tab_off[g])
      );
    end
  endgenerate

  // ---------------- header fields at cell start ----------------
  logic [DEST_W-1:0] live_dest;
  logic              live_first;
  logic              live_last;
  logic [WORD_W-1:0] live_off;
  logic [CHK_W-1:0]  live_chunks;

  always_comb begin
    live_dest   = '0;
    live_first  = 1'b0;
    live_last   = 1'b0;
    live_off    = '0;
    live_chunks = '0;
    case (pick)
      CT_PAT: begin
        live_first  = 1'b1;
        live_last   = 1'b1;
        live_off    = WORD_W'(PAY_CHUNKS);
        live_chunks = CHK_W'(PAY_CHUNKS);
      end
      CT_RT: begin
        live_dest   = rt_dest;
        live_first  = rt_first;
        live_last   = rt_last;
        live_off    = tab_off[0];
        live_chunks = tab_chunks[0];
      end
      CT_NRT: begin
        live_dest   = nrt_dest;
        live_first  = nrt_first;
        live_last   = nrt_last;
        live_off    = tab_off[1];
        live_chunks = tab_chunks[1];
      end
      default: ;
    endcase
  end

  logic [WORD_W-1:0]           tx_seq_q;
  logic [WORD_W-1:0]           cmd_word;
  logic [2*WORD_W-1:0]         init_word;
  logic [HDR_WORDS*WORD_W-1:0] live_words;
  logic [HDR_WORDS*WORD_W-1:0] hdr_q;
  logic [HDR_WORDS*WORD_W-1:0] hdr_src;

  assign cmd_word  = pack_cmd(live_dest, live_first, live_last, pick, init_req);
  assign init_word = init_req ? init_data : '0;

  // word 0 sits in the least significant bits
  assign live_words = {err_cnts, rx_next_seq, tx_seq_q,
                       loc_rt_full, loc_nrt_full, loc_rt_free, loc_nrt_free,
                       init_word[WORD_W-1:0], init_word[2*WORD_W-1:WORD_W],
                       live_off, cmd_word};

  assign hdr_src = cell_start ? live_words : hdr_q;

  cell_type_e       sel_q;
  logic [CHK_W-1:0] used_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_q    <= '0;
      sel_q    <= CT_NOP;
      used_q   <= '0;
      tx_seq_q <= '0;
    end else if (cell_start) begin
      hdr_q    <= live_words;
      sel_q    <= pick;
      used_q   <= live_chunks;
      tx_seq_q <= tx_seq_q + 1'b1;
    end
  end

  // ---------------- byte selection ----------------
  logic [7:0]       hdr_byte;
  logic [IDX_W-1:0] used_bytes;
  logic             pay_live;
  logic [7:0]       pay_byte;
  logic [7:0]       next_byte;

  lcf_hdr_sel #(.NWORDS(HDR_WORDS)) u_hsel (
    .words (hdr_src),
    .bsel  (idx_q[HB_W-1:0]),
    .hbyte (hdr_byte)
  );

  assign used_bytes = IDX_W'(used_q) * IDX_W'(CHUNK_BYTES);
  assign pay_live   = in_pay && (pay_pos < used_bytes);
  assign pat_rd     = pay_live && (sel_q == CT_PAT);
  assign rt_rd      = pay_live && (sel_q == CT_RT);
  assign nrt_rd     = pay_live && (sel_q == CT_NRT);

  always_comb begin
    case (sel_q)
      CT_PAT:  pay_byte = pat_data;
      CT_RT:   pay_byte = rt_data;
      CT_NRT:  pay_byte = nrt_data;
      default: pay_byte = 8'h00;
    endcase
    if (in_hdr)        next_byte = hdr_byte;
    else if (pay_live) next_byte = pay_byte;
    else               next_byte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_byte <= 8'h00;
      out_sof  <= 1'b0;
    end else begin
      out_byte <= next_byte;
      out_sof  <= cell_start;
    end
  end
endmodule

// File: rtl/lcf_chk.sv
module lcf_chk
  import lcf_pkg::*;
#(
  parameter int CELL_BYTES = 608,
  localparam int CNT_W     = $clog2(CELL_BYTES) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_sof,
  input logic              pat_req,
  input logic              rt_req,
  input logic [DEST_W-1:0] rt_dest,
  input logic              nrt_req,
  input logic [DEST_W-1:0] nrt_dest,
  input logic [NDEST-1:0]  peer_rt_avail,
  input logic [NDEST-1:0]  peer_nrt_avail,
  input logic              pat_gnt,
  input logic              rt_gnt,
  input logic              nrt_gnt,
  input logic              pat_rd,
  input logic              rt_rd,
  input logic              nrt_rd,
  input logic              init_ack,
  input logic              cell_start,
  input logic [WORD_W-1:0] tx_seq_q
);
  logic [CNT_W-1:0] since_sof;
  logic             sof_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_sof <= '0;
      sof_seen  <= 1'b0;
    end else begin
      since_sof <= out_sof ? '0 : since_sof + 1'b1;
      sof_seen  <= sof_seen | out_sof;
    end
  end

  // R1
  sof_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof && sof_seen) |-> (since_sof == CNT_W'(CELL_BYTES - 1)));

  // R1
  sof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |=> !out_sof);

  // R7
  rt_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_gnt |-> !pat_req);

  // R7
  nrt_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nrt_gnt |-> (!pat_req && !(rt_req && peer_rt_avail[rt_dest])));

  // R7
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pat_gnt, rt_gnt, nrt_gnt}));

  // R8
  rt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_gnt |-> (rt_req && peer_rt_avail[rt_dest]));

  // R8
  nrt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nrt_gnt |-> (nrt_req && peer_nrt_avail[nrt_dest]));

  // R10
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pat_rd, rt_rd, nrt_rd}));

  // R4
  init_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_ack |=> !init_ack);

  // R6
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start |=> (tx_seq_q == $past(tx_seq_q) + 1'b1));
endmodule

bind link_cell_framer lcf_chk #(.CELL_BYTES(CELL_BYTES)) u_lcf_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .out_sof        (out_sof),
  .pat_req        (pat_req),
  .rt_req         (rt_req),
  .rt_dest        (rt_dest),
  .nrt_req        (nrt_req),
  .nrt_dest       (nrt_dest),
  .peer_rt_avail  (peer_rt_avail),
  .peer_nrt_avail (peer_nrt_avail),
  .pat_gnt        (pat_gnt),
  .rt_gnt         (rt_gnt),
  .nrt_gnt        (nrt_gnt),
  .pat_rd         (pat_rd),
  .rt_rd          (rt_rd),
  .nrt_rd         (nrt_rd),
  .init_ack       (init_ack),
  .cell_start     (cell_start),
  .tx_seq_q       (tx_seq_q)
);

// File: tb/test_link_cell_framer.sv
module test_link_cell_framer;
  localparam int CLK_PERIOD = 10;
  localparam int CELL  = 608;
  localparam int HDRB  = 32;
  localparam int PAYB  = 320;
  localparam int T_PAT = 0;
  localparam int T_RT  = 1;
  localparam int T_NRT = 2;
  localparam int T_NOP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pat_req = 1'b0, pat_gnt, pat_rd;
  logic [7:0]  pat_data, rt_data, nrt_data;
  logic        rt_req = 1'b0, rt_first = 1'b0, rt_last = 1'b0, rt_gnt, rt_rd;
  logic [3:0]  rt_dest = '0, nrt_dest = '0;
  logic [2:0]  rt_chunks = '0, nrt_chunks = '0;
  logic        nrt_req = 1'b0, nrt_first = 1'b0, nrt_last = 1'b0, nrt_gnt, nrt_rd;
  logic [15:0] peer_rt_avail = 16'hFFDF, peer_nrt_avail = 16'hFFFF;
  logic        init_req = 1'b0, init_ack;
  logic [31:0] init_data = '0;
  logic [15:0] loc_nrt_free = '0, loc_rt_free = '0, loc_nrt_full = '0, loc_rt_full = '0;
  logic [15:0] rx_next_seq = '0;
  logic [95:0] err_cnts = '0;
  logic [7:0]  out_byte;
  logic        out_sof;

  link_cell_framer i_link_cell_framer (
    .clk(clk), .rst_n(rst_n),
    .pat_req(pat_req), .pat_gnt(pat_gnt), .pat_rd(pat_rd), .pat_data(pat_data),
    .rt_req(rt_req), .rt_dest(rt_dest), .rt_first(rt_first), .rt_last(rt_last),
    .rt_chunks(rt_chunks), .rt_gnt(rt_gnt), .rt_rd(rt_rd), .rt_data(rt_data),
    .nrt_req(nrt_req), .nrt_dest(nrt_dest), .nrt_first(nrt_first), .nrt_last(nrt_last),
    .nrt_chunks(nrt_chunks), .nrt_gnt(nrt_gnt), .nrt_rd(nrt_rd), .nrt_data(nrt_data),
    .peer_rt_avail(peer_rt_avail), .peer_nrt_avail(peer_nrt_avail),
    .init_req(init_req), .init_data(init_data), .init_ack(init_ack),
    .loc_nrt_free(loc_nrt_free), .loc_rt_free(loc_rt_free),
    .loc_nrt_full(loc_nrt_full), .loc_rt_full(loc_rt_full),
    .rx_next_seq(rx_next_seq), .err_cnts(err_cnts),
    .out_byte(out_byte), .out_sof(out_sof)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // payload source models: byte = {tag, position bits}
  logic [8:0] pat_cnt = '0, rt_cnt = '0, nrt_cnt = '0;
  assign pat_data = {2'd1, pat_cnt[5:0]};
  assign rt_data  = {2'd2, rt_cnt[5:0]};
  assign nrt_data = {2'd3, nrt_cnt[5:0]};

  int tot_rd [3];
  int tot_gnt [3];
  int tot_ack;
  initial begin
    for (int i = 0; i < 3; i++) begin tot_rd[i] = 0; tot_gnt[i] = 0; end
    tot_ack = 0;
  end

  always @(posedge clk) begin
    if (pat_gnt) pat_cnt <= '0; else if (pat_rd) pat_cnt <= pat_cnt + 1'b1;
    if (rt_gnt)  rt_cnt  <= '0; else if (rt_rd)  rt_cnt  <= rt_cnt + 1'b1;
    if (nrt_gnt) nrt_cnt <= '0; else if (nrt_rd) nrt_cnt <= nrt_cnt + 1'b1;
    if (rst_n) begin
      if (pat_rd)  tot_rd[0]  <= tot_rd[0] + 1;
      if (rt_rd)   tot_rd[1]  <= tot_rd[1] + 1;
      if (nrt_rd)  tot_rd[2]  <= tot_rd[2] + 1;
      if (pat_gnt) tot_gnt[0] <= tot_gnt[0] + 1;
      if (rt_gnt)  tot_gnt[1] <= tot_gnt[1] + 1;
      if (nrt_gnt) tot_gnt[2] <= tot_gnt[2] + 1;
      if (init_ack) tot_ack <= tot_ack + 1;
    end
  end

  int errors = 0;
  int checks = 0;
  logic [15:0] seq_exp = '0;
  logic [7:0] cell_b [CELL];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] w(input int j);
    return {cell_b[2*j], cell_b[2*j+1]};
  endfunction

  task automatic set_status();
    loc_nrt_free = 16'h1100 ^ seq_exp;
    loc_rt_free  = 16'h2200 ^ seq_exp;
    loc_nrt_full = 16'h3300 ^ seq_exp;
    loc_rt_full  = 16'h4400 ^ seq_exp;
    rx_next_seq  = 16'h7000 ^ seq_exp;
    for (int k = 0; k < 6; k++) err_cnts[16*k +: 16] = 16'h0A00 + 16'(k * 257) + seq_exp;
  endtask

  // capture one cell and check it against the expected layout
  task automatic run_cell(input int ctype, input logic [3:0] dest, input bit first,
                          input bit last, input bit we, input logic [15:0] off,
                          input int used, input logic [31:0] idata, input string req);
    int rd0 [3];
    int gnt0 [3];
    int ack0;
    int sof_bad;
    int bad_pay;
    int bad_ecc;
    int first_bad;
    logic [7:0] expb;
    logic [15:0] cmd_exp;
    logic [15:0] st_exp [6];
    logic [15:0] cnt_exp [6];
    set_status();
    st_exp[0] = loc_nrt_free; st_exp[1] = loc_rt_free;
    st_exp[2] = loc_nrt_full; st_exp[3] = loc_rt_full;
    st_exp[5] = rx_next_seq;
    for (int k = 0; k < 6; k++) cnt_exp[k] = err_cnts[16*k +: 16];
    for (int i = 0; i < 3; i++) begin rd0[i] = tot_rd[i]; gnt0[i] = tot_gnt[i]; end
    ack0 = tot_ack;
    sof_bad = 0;
    do @(negedge clk); while (!out_sof);
    cell_b[0] = out_byte;
    for (int j = 1; j < CELL; j++) begin
      @(negedge clk);
      cell_b[j] = out_byte;
      if (out_sof) sof_bad++;
    end
    // R1: no start marker inside the cell, and the next one follows at once
    chk(sof_bad == 0, "R1", "start marker inside cell", sof_bad, 0);
    cmd_exp = {dest, first, last, 2'(ctype), we, 7'd0};
    // R2 layout, plus the scenario's own requirement on the selected type
    chk(w(0) == cmd_exp, "R2", "command word", w(0), cmd_exp);
    chk(w(0)[9:8] == 2'(ctype), req, "cell type", w(0)[9:8], ctype);
    chk(w(1) == off, "R3", "buffer offset", w(1), off);
    chk({w(2), w(3)} == idata, "R4", "init data words", {w(2), w(3)}, idata);
    chk(tot_ack - ack0 == int'(we), "R4", "init ack pulses", tot_ack - ack0, we);
    for (int k = 0; k < 4; k++)
      chk(w(4 + k) == st_exp[k], "R5", "bitmap word", w(4 + k), st_exp[k]);
    chk(w(9) == st_exp[5], "R5", "expected rx seq", w(9), st_exp[5]);
    for (int k = 0; k < 6; k++)
      chk(w(10 + k) == cnt_exp[k], "R5", "counter word", w(10 + k), cnt_exp[k]);
    chk(w(8) == seq_exp, "R6", "tx sequence", w(8), seq_exp);
    seq_exp = seq_exp + 16'd1;
    bad_pay = 0; first_bad = -1;
    for (int k = 0; k < PAYB; k++) begin
      expb = (k < used * 64) ? {2'(ctype + 1), 6'(k)} : 8'h00;
      if (cell_b[HDRB + k] !== expb) begin
        bad_pay++;
        if (first_bad < 0) first_bad = k;
      end
    end
    chk(bad_pay == 0, (ctype == T_NOP) ? "R9" : "R10", "payload bytes wrong, first at",
        first_bad, -1);
    bad_ecc = 0;
    for (int k = HDRB + PAYB; k < CELL; k++) if (cell_b[k] !== 8'h00) bad_ecc++;
    chk(bad_ecc == 0, "R11", "nonzero ecc bytes", bad_ecc, 0);
    for (int i = 0; i < 3; i++) begin
      chk(tot_rd[i] - rd0[i] == ((i == ctype) ? used * 64 : 0), "R10", "read strobes",
          tot_rd[i] - rd0[i], (i == ctype) ? used * 64 : 0);
      chk(tot_gnt[i] - gnt0[i] == ((i == ctype) ? 1 : 0), "R7", "grant pulses",
          tot_gnt[i] - gnt0[i], (i == ctype) ? 1 : 0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    // R12
    chk(out_byte == 8'h00, "R12", "out_byte in reset", out_byte, 0);
    chk(out_sof == 1'b0, "R12", "out_sof in reset", out_sof, 0);
    chk(init_ack == 1'b0, "R12", "init_ack in reset", init_ack, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle();
    // R9: nothing requested, no-op cell
    pat_req = 0; rt_req = 0; nrt_req = 0;
    run_cell(T_NOP, 4'd0, 0, 0, 0, 16'd0, 0, 32'd0, "R9");
  endtask

  task automatic t_pattern_wins();
    // R7: pattern beats ready buffer sources
    pat_req = 1;
    rt_req = 1; rt_dest = 4'd3; rt_first = 1; rt_last = 0; rt_chunks = 3'd2;
    nrt_req = 1; nrt_dest = 4'd1; nrt_first = 1; nrt_last = 0; nrt_chunks = 3'd1;
    run_cell(T_PAT, 4'd0, 1, 1, 0, 16'd5, 5, 32'd0, "R7");
  endtask

  task automatic t_rt_over_nrt();
    // R7: real-time beats non-real-time, partial payload padded (R10)
    pat_req = 0;
    run_cell(T_RT, 4'd3, 1, 0, 0, 16'd2, 2, 32'd0, "R7");
  endtask

  task automatic t_offsets();
    // R3: independent running counts per destination
    nrt_req = 0;
    rt_dest = 4'd7; rt_first = 1; rt_last = 0; rt_chunks = 3'd4;
    run_cell(T_RT, 4'd7, 1, 0, 0, 16'd4, 4, 32'd0, "R3");
    rt_dest = 4'd3; rt_first = 0; rt_last = 1; rt_chunks = 3'd5;
    run_cell(T_RT, 4'd3, 0, 1, 0, 16'd7, 5, 32'd0, "R3");
  endtask

  task automatic t_peer_gate();
    // R8: blocked real-time lets non-real-time through
    rt_dest = 4'd5; rt_first = 1; rt_last = 0; rt_chunks = 3'd2;
    nrt_req = 1; nrt_dest = 4'd9; nrt_first = 1; nrt_last = 0; nrt_chunks = 3'd3;
    run_cell(T_NRT, 4'd9, 1, 0, 0, 16'd3, 3, 32'd0, "R8");
  endtask

  task automatic t_init_write();
    // R4: init write rides on a non-real-time continuation cell
    nrt_first = 0; nrt_last = 1; nrt_chunks = 3'd1;
    init_req = 1; init_data = 32'hCAFE_1234;
    run_cell(T_NRT, 4'd9, 0, 1, 1, 16'd4, 1, 32'hCAFE_1234, "R4");
    init_req = 0; init_data = 32'h0;
  endtask

  task automatic t_all_blocked();
    // R8: both buffer requests blocked by the peer, no-op goes out
    peer_nrt_avail = 16'hFDFF;
    nrt_first = 1; nrt_chunks = 3'd2;
    run_cell(T_NOP, 4'd0, 0, 0, 0, 16'd0, 0, 32'd0, "R8");
    peer_nrt_avail = 16'hFFFF;
  endtask

  task automatic t_clamp();
    // R10: a chunk count above the slot is taken as a full slot
    nrt_req = 0;
    peer_rt_avail = 16'hFFFF;
    rt_dest = 4'd2; rt_first = 1; rt_last = 1; rt_chunks = 3'd7;
    run_cell(T_RT, 4'd2, 1, 1, 0, 16'd5, 5, 32'd0, "R10");
    rt_req = 0;
    run_cell(T_NOP, 4'd0, 0, 0, 0, 16'd0, 0, 32'd0, "R6");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL R1 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_pattern_wins();
    t_rt_over_nrt();
    t_offsets();
    t_peer_gate();
    t_init_write();
    t_all_blocked();
    t_clamp();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule